// File: doc/BRIEF.md
# Circular Scan Checkpoint Manager

This block takes a non-destructive snapshot of one sub-module's state elements. The state elements of the chosen sub-module are threaded into a single full-scan chain. When a checkpoint is requested, the manager stops the sub-module's functional clock enable and rotates the chain through exactly one full chain length. Every bit that leaves the chain tail goes back into the chain head in the same cycle. The same bit is also presented on a serial host output with a valid strobe. When the rotation ends, each flop holds the value it had before the checkpoint, and functional operation resumes. State is captured only at checkpoints, never continuously.

Each accepted checkpoint advances a modulo counter. The counter value is presented as the snapshot tag for the whole frame. A request that arrives while a snapshot is in progress is dropped.

The control is a four-state machine:
- **Idle**: functional enable high, not busy. A request takes the transition *accept* to Freeze and bumps the tag.
- **Freeze**: one cycle with the enable low and no shifting. The transition *start* leads to Shift.
- **Shift**: exactly `CHAIN_LEN` cycles with the chain shifting in a loop. The transition *last* leads to Done.
- **Done**: one cycle that marks the end of the frame. The transition *resume* returns to Idle.

Top module: `scan_ckpt_mgr`

## Requirements
- R1: After reset the block is in Idle: `func_en_o`=1, `busy_o`=0, `chain_shift_o`=0, `host_valid_o`=0, `snap_done_o`=0, `snap_id_o`=0.
- R2: A request sampled high in Idle causes one Freeze cycle in the next cycle. In that cycle `busy_o`=1, `func_en_o`=0 and `chain_shift_o`=0.
- R3: Each snapshot holds `chain_shift_o` high for exactly `CHAIN_LEN` consecutive cycles.
- R4: While `chain_shift_o` is high, `chain_head_o` equals `chain_tail_i` in the same cycle. Otherwise `chain_head_o` is 0.
- R5: In every shift cycle, `host_valid_o`=1 and `host_bit_o` equals `chain_tail_i`. The frame therefore carries the last flop of the chain first. `host_valid_o` is 0 outside shift cycles.
- R6: When `snap_done_o` is high, every flop of the chain holds the value it had when Freeze began.
- R7: `func_en_o` is low from Freeze through Done. Done lasts one cycle with `snap_done_o`=1. The next cycle is Idle with `func_en_o`=1 and `busy_o`=0.
- R8: `snap_id_o` increases by one, modulo 2^`ID_W`, at the edge that accepts a request. It holds that value throughout the snapshot.
- R9: A request while `busy_o` is high is ignored. It changes neither `snap_id_o` nor the frame, and it starts no further snapshot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ckpt_req_i | input | 1 | Checkpoint request |
| chain_tail_i | input | 1 | Bit from the last flop of the scan chain |
| chain_head_o | output | 1 | Bit into the first flop of the scan chain |
| chain_shift_o | output | 1 | Scan enable of the chain |
| func_en_o | output | 1 | Functional clock enable of the sub-module |
| busy_o | output | 1 | Snapshot in progress |
| host_bit_o | output | 1 | Serial snapshot bit to the host |
| host_valid_o | output | 1 | host_bit_o carries a chain bit |
| snap_done_o | output | 1 | One-cycle end-of-frame marker |
| snap_id_o | output | ID_W | Snapshot tag |

## Verification
The assertions check the following on every cycle:
- the loopback and host bit against the chain tail,
- that the enable never overlaps shifting,
- that Done always follows a shift cycle,
- the tag step on accept, and its stability under requests while busy.

The bench scenarios cover what spans a whole frame. They run a model chain whose functional update changes its state each cycle. They check that the serial bits arrive last flop first, that the shift count equals the chain length, that the chain is restored bit for bit, that the tag wraps, and that requests made mid-frame leave no trace.

// File: rtl/scan_ckpt_pkg.sv
package scan_ckpt_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FREEZE = 2'd1,
        ST_SHIFT  = 2'd2,
        ST_DONE   = 2'd3
    } ckpt_state_e;

    typedef struct packed {
        logic func_en;
        logic busy;
        logic shift;
        logic done;
    } ckpt_ctrl_t;
endpackage

// File: rtl/scan_shift_counter.sv
module scan_shift_counter #(
    parameter int CHAIN_LEN = 24
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic run_i,
    output logic last_o
);
    localparam int CW = (CHAIN_LEN > 1) ? $clog2(CHAIN_LEN) : 1;
    localparam logic [CW-1:0] LAST = CW'(CHAIN_LEN - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else if (run_i) begin
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end else begin
            cnt_q <= '0;
        end
    end

    assign last_o = run_i && (cnt_q == LAST);
endmodule

// File: rtl/scan_loop_path.sv
module scan_loop_path (
    input  logic shift_i,
    input  logic tail_i,
    output logic head_o,
    output logic host_bit_o,
    output logic host_valid_o
);
    always_comb begin
        head_o       = shift_i ? tail_i : 1'b0;
        host_bit_o   = shift_i ? tail_i : 1'b0;
        host_valid_o = shift_i;
    end
endmodule

// File: rtl/checkpoint_tally.sv
module checkpoint_tally #(
    parameter int ID_W = 8
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            inc_i,
    output logic [ID_W-1:0] id_o
);
    logic [ID_W-1:0] id_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            id_q <= '0;
        end else if (inc_i) begin
            id_q <= id_q + 1'b1;
        end
    end

    assign id_o = id_q;
endmodule

// File: rtl/scan_ckpt_mgr.sv
module scan_ckpt_mgr
    import scan_ckpt_pkg::*;
#(
    parameter int CHAIN_LEN = 24,
    parameter int ID_W      = 8
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            ckpt_req_i,
    input  logic            chain_tail_i,
    output logic            chain_head_o,
    output logic            chain_shift_o,
    output logic            func_en_o,
    output logic            busy_o,
    output logic            host_bit_o,
    output logic            host_valid_o,
    output logic            snap_done_o,
    output logic [ID_W-1:0] snap_id_o
);
    ckpt_state_e state_q, state_d;
    ckpt_ctrl_t  ctrl;
    logic        shift_last;
    logic        accept;

    assign accept = (state_q == ST_IDLE) && ckpt_req_i;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (ckpt_req_i) state_d = ST_FREEZE;   // accept
            ST_FREEZE: state_d = ST_SHIFT;                    // start
            ST_SHIFT:  if (shift_last) state_d = ST_DONE;     // last
            ST_DONE:   state_d = ST_IDLE;                     // resume
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // output decode
    always_comb begin
        ctrl = '{func_en: 1'b1, busy: 1'b0, shift: 1'b0, done: 1'b0};
        unique case (state_q)
            ST_IDLE:   ctrl = '{func_en: 1'b1, busy: 1'b0, shift: 1'b0, done: 1'b0};
            ST_FREEZE: ctrl = '{func_en: 1'b0, busy: 1'b1, shift: 1'b0, done: 1'b0};
            ST_SHIFT:  ctrl = '{func_en: 1'b0, busy: 1'b1, shift: 1'b1, done: 1'b0};
            ST_DONE:   ctrl = '{func_en: 1'b0, busy: 1'b1, shift: 1'b0, done: 1'b1};
            default:   ctrl = '{func_en: 1'b1, busy: 1'b0, shift: 1'b0, done: 1'b0};
        endcase
    end

    assign func_en_o     = ctrl.func_en;
    assign busy_o        = ctrl.busy;
    assign chain_shift_o = ctrl.shift;
    assign snap_done_o   = ctrl.done;

    scan_shift_counter #(.CHAIN_LEN(CHAIN_LEN)) i_shift_cnt (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .run_i  (ctrl.shift),
        .last_o (shift_last)
    );

    scan_loop_path i_loop (
        .shift_i      (ctrl.shift),
        .tail_i       (chain_tail_i),
        .head_o       (chain_head_o),
        .host_bit_o   (host_bit_o),
        .host_valid_o (host_valid_o)
    );

    checkpoint_tally #(.ID_W(ID_W)) i_tally (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .inc_i  (accept),
        .id_o   (snap_id_o)
    );

    // R4: loopback keeps the chain contents circulating
    assert_loopback_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        chain_shift_o |-> (chain_head_o == chain_tail_i));

    // R5: host sees the same bit that re-enters the chain
    assert_host_bit_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        host_valid_o |-> (host_bit_o == chain_tail_i));

    // R7: the functional enable never overlaps shifting
    assert_frozen_shift_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        chain_shift_o |-> !func_en_o);

    // R3: Done is only reached straight from a shift cycle
    assert_done_after_shift_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(snap_done_o) |-> $past(chain_shift_o));

    // R8: the tag steps by one when a snapshot starts
    assert_tag_step_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(busy_o) |-> (snap_id_o == ID_W'($past(snap_id_o) + 1'b1)));

    // R9: requests during a snapshot leave the tag untouched
    assert_ignore_busy_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && ckpt_req_i) |=> $stable(snap_id_o));
endmodule

// File: tb/test_scan_ckpt_mgr.sv
module test_scan_ckpt_mgr;
    localparam int LEN  = 24;
    localparam int ID_W = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req = 1'b0;
    logic tail, head, shift, func_en, busy, hbit, hvalid, done;
    logic [ID_W-1:0] sid;

    logic [LEN-1:0] chain;
    int checks = 0;
    int errors = 0;
    int shift_cycles = 0;
    logic [ID_W-1:0] exp_id = '0;
    logic [LEN-1:0]  snapshot;
    bit              bit_q[$];

    always #2 clk = ~clk;   // 250 MHz

    scan_ckpt_mgr #(.CHAIN_LEN(LEN), .ID_W(ID_W)) i_scan_ckpt_mgr (
        .clk_i(clk), .rst_ni(rst_n), .ckpt_req_i(req), .chain_tail_i(tail),
        .chain_head_o(head), .chain_shift_o(shift), .func_en_o(func_en),
        .busy_o(busy), .host_bit_o(hbit), .host_valid_o(hvalid),
        .snap_done_o(done), .snap_id_o(sid)
    );

    // model sub-module: scan chain with a functional update
    assign tail = chain[LEN-1];
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      chain <= 24'hA5C396;
        else if (shift)  chain <= {chain[LEN-2:0], head};
        else if (func_en) chain <= chain + 24'h013579;
    end

    task automatic chk(input bit ok, input string req_tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req_tag, act, exp);
        end
    endtask

    // monitor: pops expected bits as the design emits them
    always @(negedge clk) begin
        if (rst_n) begin
            if (shift) chk(head == tail, "R4 loopback", head, tail);
            else       chk(head == 1'b0, "R4 idle head", head, 0);
            chk(hvalid == shift, "R5 valid", hvalid, shift);
            if (hvalid) begin
                shift_cycles++;
                if (bit_q.size() == 0) begin
                    chk(0, "R5 unexpected bit", hbit, 0);
                end else begin
                    bit exp_b;
                    exp_b = bit_q.pop_front();
                    chk(hbit == exp_b, "R5 host bit", hbit, exp_b);
                end
            end
            if (done) begin
                chk(shift_cycles == LEN, "R3 shift count", shift_cycles, LEN);
                chk(bit_q.size() == 0, "R5 frame complete", bit_q.size(), 0);
                chk(chain == snapshot, "R6 chain restored", chain, snapshot);
                chk(sid == exp_id, "R8 tag at done", sid, exp_id);
                chk(func_en == 1'b0, "R7 frozen in done", func_en, 0);
                shift_cycles = 0;
            end
        end
    end

    // driver: requests a checkpoint and pushes the expected frame
    task automatic do_ckpt(input bit poke_busy);
        @(negedge clk); req = 1'b1;
        @(negedge clk); req = 1'b0;
        exp_id   = exp_id + 1'b1;
        snapshot = chain;
        for (int i = LEN - 1; i >= 0; i--) bit_q.push_back(snapshot[i]);
        chk(busy && !func_en && !shift, "R2 freeze", {busy, func_en, shift}, 3'b100);
        chk(sid == exp_id, "R8 tag on accept", sid, exp_id);
        if (poke_busy) begin
            repeat (4) @(negedge clk);
            req = 1'b1;
            repeat (3) @(negedge clk);
            req = 1'b0;
            chk(sid == exp_id, "R9 tag unchanged", sid, exp_id);
        end
        while (!done) @(negedge clk);
        @(negedge clk);
        chk(!busy && func_en, "R7 resume", {busy, func_en}, 2'b01);
        repeat (3) @(negedge clk);
        chk(!busy && !shift && sid == exp_id, "R9 no extra snapshot", {busy, shift, sid}, {2'b00, exp_id});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(func_en && !busy && !shift && !hvalid && !done && sid == 0,
            "R1 reset", {func_en, busy, shift, hvalid, done, sid}, 8'h80);
        rst_n = 1'b1;
        @(negedge clk);
        chk(func_en && !busy, "R1 idle", {func_en, busy}, 2'b10);
        do_ckpt(1'b0);
        do_ckpt(1'b1);
        repeat (5) @(negedge clk);
        for (int k = 0; k < 8; k++) begin
            do_ckpt(k[0]);
            repeat (k) @(negedge clk);
        end
        chk(sid == exp_id, "R8 wrap", sid, exp_id);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule